// File: doc/BRIEF.md
# Synchronous Bus Acknowledge Controller

This block is the slave-side glue for a 16-bit processor bus of the strobe-and-acknowledge kind, run in step with the processor clock. It watches the word address (bits 23 down to 1, with no byte-address bit), the function code, the read/write line, the address strobe and the two byte strobes. For every bus cycle it picks the target device from the address and answers with either an active-low transfer acknowledge or an active-low bus error. Writes are acknowledged with no wait state and parked in a one-entry posting buffer, which hands them to the device over its own valid/ready channel. Reads go to the device over a second valid/ready channel and are acknowledged one clock after the device accepts.

The address space is cut into equal windows of 2^WIN_W words. Window index `addr_i[ADDR_W-1:WIN_W]` selects device 0 to NDEV-1, and higher windows are unmapped. The lowest PROT_WORDS words (the exception table) accept writes only from supervisor function codes. Both device channels follow the usual rules: a request is offered with `*_valid_o`, it completes on the first rising edge where the selected device's `*_ready_i` bit is high, and the controller never changes the request's contents while it waits. A device may hold its ready bit low for any number of cycles, and the processor sees each of those cycles as a wait state.

Top module: `bus_ack_ctrl`

## Requirements
- R1: After reset, `dtack_n_o` and `berr_n_o` are high and `rd_valid_o` and `wr_valid_o` are low.
- R2: A bus cycle whose window index is NDEV or above gets `berr_n_o` low at the clock edge that first sees the address strobe and a byte strobe low, and it raises no read or write request.
- R3: A permitted write to a mapped device, with the posting buffer empty, gets `dtack_n_o` low at that first edge. From the next cycle the buffer offers it with `wr_sel_o` equal to the window index, the word address, the data and `wr_be_o` = {upper strobe active, lower strobe active}, where bit 1 is the upper byte.
- R4: A read raises `rd_valid_o` after the first edge. `dtack_n_o` falls at the edge after the selected device takes the request, and `rdata_o` carries the device data while `dtack_n_o` is low. A device that is always ready gives acknowledge one edge after the first edge.
- R5: Each cycle that the selected read device holds its ready bit low delays the acknowledge by one cycle.
- R6: While the selected device's `wr_ready_i` bit is low, `wr_valid_o` stays high and the select, address, data and byte enables do not change. The entry clears on the edge where that bit is high.
- R7: A read to the device that owns the pending posted write does not raise `rd_valid_o` until the entry has drained.
- R8: A write that arrives while the buffer is full, for any device, gets no acknowledge until the entry has drained. It is acknowledged and posted at the next edge after the drain.
- R9: A write into words 0 to PROT_WORDS-1 gets a bus error and is not posted unless the function code is 101 or 110 (supervisor). Supervisor writes there, user writes at PROT_WORDS and above, and reads by any function code are acknowledged.
- R10: `dtack_n_o` and `berr_n_o` are never low together. Both are high after the first edge that samples the address strobe high.
- R11: A read to a device other than the one that owns the pending posted write proceeds with no added wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W | Word address (byte bits 23..1) |
| fc_i | input | 3 | Function code |
| as_n_i | input | 1 | Address strobe, active low |
| uds_n_i | input | 1 | Upper byte strobe, active low |
| lds_n_i | input | 1 | Lower byte strobe, active low |
| rw_n_i | input | 1 | High for read, low for write |
| wdata_i | input | DW | Write data from the processor |
| rdata_o | output | DW | Read data to the processor |
| dtack_n_o | output | 1 | Transfer acknowledge, active low |
| berr_n_o | output | 1 | Bus error, active low |
| rd_valid_o | output | 1 | Read request valid |
| rd_ready_i | input | NDEV | Per-device read ready |
| rd_sel_o | output | DEV_W | Read target device |
| rd_addr_o | output | ADDR_W | Read word address |
| rd_be_o | output | 2 | Read byte enables |
| rd_data_i | input | DW | Data from the selected device, taken when it is ready |
| wr_valid_o | output | 1 | Posted write valid |
| wr_ready_i | input | NDEV | Per-device write ready |
| wr_sel_o | output | DEV_W | Posted write target device |
| wr_addr_o | output | ADDR_W | Posted write word address |
| wr_data_o | output | DW | Posted write data |
| wr_be_o | output | 2 | Posted write byte enables |

## Verification
The properties assume the processor behaves as a bus master should. It holds the address strobe low, with address, function code, direction and data steady, until it has seen the acknowledge or the error. It also raises the strobe for at least one sampled cycle between bus cycles. The stimulus drives every bus cycle through one task that changes pins only on falling clock edges, holds them until the response appears, and then releases all strobes together for a full cycle. Device ready bits are set only between edges and are held low whenever a test needs to watch a pending request.

// File: rtl/bac_pkg.sv
package bac_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_HOLD = 2'd3
  } bac_state_e;

  localparam logic [2:0] FC_SUP_DATA = 3'b101;
  localparam logic [2:0] FC_SUP_PROG = 3'b110;

  function automatic logic fc_is_super(input logic [2:0] fc);
    return (fc == FC_SUP_DATA) || (fc == FC_SUP_PROG);
  endfunction

endpackage

// File: rtl/bac_decode.sv
module bac_decode #(
  parameter int ADDR_W     = 23,
  parameter int NDEV       = 3,
  parameter int WIN_W      = 16,
  parameter int PROT_WORDS = 512,
  parameter int DEV_W      = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        fc_i,
  input  logic              is_wr_i,
  output logic [DEV_W-1:0]  dev_o,
  output logic              mapped_o,
  output logic              deny_o
);
  localparam int SEL_W = ADDR_W - WIN_W;

  logic [SEL_W-1:0] win;
  logic [NDEV-1:0]  hit;
  logic             in_prot;

  assign win = addr_i[ADDR_W-1:WIN_W];

  // one comparator per device window
  for (genvar g = 0; g < NDEV; g++) begin : g_hit
    assign hit[g] = (win == SEL_W'(g));
  end

  always_comb begin
    dev_o = '0;
    for (int i = 0; i < NDEV; i++) begin
      if (hit[i]) dev_o = DEV_W'(i);
    end
  end

  assign mapped_o = |hit;
  assign in_prot  = (addr_i < ADDR_W'(PROT_WORDS));
  assign deny_o   = is_wr_i && in_prot && !bac_pkg::fc_is_super(fc_i);

endmodule

// File: rtl/bac_post_buf.sv
module bac_post_buf #(
  parameter int ADDR_W = 23,
  parameter int DW     = 16,
  parameter int NDEV   = 3,
  parameter int DEV_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DEV_W-1:0]  dev_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     data_i,
  input  logic [1:0]        be_i,
  input  logic [NDEV-1:0]   ready_i,
  output logic              full_o,
  output logic [DEV_W-1:0]  dev_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DW-1:0]     data_o,
  output logic [1:0]        be_o
);
  logic drain;

  assign drain = full_o && ready_i[dev_o];

  // load is only requested while the entry is empty, so it never meets a drain
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_o <= 1'b0;
      dev_o  <= '0;
      addr_o <= '0;
      data_o <= '0;
      be_o   <= '0;
    end else if (load_i) begin
      full_o <= 1'b1;
      dev_o  <= dev_i;
      addr_o <= addr_i;
      data_o <= data_i;
      be_o   <= be_i;
    end else if (drain) begin
      full_o <= 1'b0;
    end
  end

endmodule

// File: rtl/bac_seq.sv
module bac_seq
  import bac_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int DW     = 16,
  parameter int NDEV   = 3,
  parameter int DEV_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_n_i,
  input  logic              uds_n_i,
  input  logic              lds_n_i,
  input  logic              rw_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DEV_W-1:0]  dev_i,
  input  logic              mapped_i,
  input  logic              deny_i,
  input  logic              buf_full_i,
  input  logic [DEV_W-1:0]  buf_dev_i,
  input  logic [NDEV-1:0]   rd_ready_i,
  input  logic [DW-1:0]     rd_data_i,
  output logic              load_o,
  output logic              rd_valid_o,
  output logic [DEV_W-1:0]  cur_dev_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [1:0]        cur_be_o,
  output logic [DW-1:0]     rdata_o,
  output logic              ack_o,
  output logic              err_o
);
  bac_state_e state;
  logic       start;
  logic       rd_fire;
  logic       rd_blocked;

  assign start      = (state == ST_IDLE) && !as_n_i && (!uds_n_i || !lds_n_i);
  assign rd_blocked = buf_full_i && (buf_dev_i == cur_dev_o);
  assign rd_valid_o = (state == ST_RD) && !rd_blocked;
  assign rd_fire    = rd_valid_o && rd_ready_i[cur_dev_o];

  assign load_o = (start && !rw_n_i && mapped_i && !deny_i && !buf_full_i) ||
                  ((state == ST_WR) && !buf_full_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      ack_o      <= 1'b0;
      err_o      <= 1'b0;
      cur_dev_o  <= '0;
      cur_addr_o <= '0;
      cur_be_o   <= '0;
      rdata_o    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            cur_dev_o  <= dev_i;
            cur_addr_o <= addr_i;
            cur_be_o   <= {!uds_n_i, !lds_n_i};
            if (!mapped_i || deny_i) begin
              err_o <= 1'b1;
              state <= ST_HOLD;
            end else if (!rw_n_i) begin
              if (!buf_full_i) begin
                ack_o <= 1'b1;
                state <= ST_HOLD;
              end else begin
                state <= ST_WR;
              end
            end else begin
              state <= ST_RD;
            end
          end
        end
        ST_RD: begin
          if (rd_fire) begin
            rdata_o <= rd_data_i;
            ack_o   <= 1'b1;
            state   <= ST_HOLD;
          end
        end
        ST_WR: begin
          if (!buf_full_i) begin
            ack_o <= 1'b1;
            state <= ST_HOLD;
          end
        end
        default: begin
          if (as_n_i) begin
            ack_o <= 1'b0;
            err_o <= 1'b0;
            state <= ST_IDLE;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/bus_ack_ctrl.sv
module bus_ack_ctrl #(
  parameter int ADDR_W     = 23,
  parameter int DW         = 16,
  parameter int NDEV       = 3,
  parameter int WIN_W      = 16,
  parameter int PROT_WORDS = 512,
  localparam int DEV_W     = (NDEV > 1) ? $clog2(NDEV) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        fc_i,
  input  logic              as_n_i,
  input  logic              uds_n_i,
  input  logic              lds_n_i,
  input  logic              rw_n_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              dtack_n_o,
  output logic              berr_n_o,
  output logic              rd_valid_o,
  input  logic [NDEV-1:0]   rd_ready_i,
  output logic [DEV_W-1:0]  rd_sel_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [1:0]        rd_be_o,
  input  logic [DW-1:0]     rd_data_i,
  output logic              wr_valid_o,
  input  logic [NDEV-1:0]   wr_ready_i,
  output logic [DEV_W-1:0]  wr_sel_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DW-1:0]     wr_data_o,
  output logic [1:0]        wr_be_o
);
  logic [DEV_W-1:0] dec_dev;
  logic             dec_mapped;
  logic             dec_deny;
  logic             load;
  logic             ack;
  logic             err;

  bac_decode #(
    .ADDR_W(ADDR_W), .NDEV(NDEV), .WIN_W(WIN_W),
    .PROT_WORDS(PROT_WORDS), .DEV_W(DEV_W)
  ) u_decode (
    .addr_i   (addr_i),
    .fc_i     (fc_i),
    .is_wr_i  (!rw_n_i),
    .dev_o    (dec_dev),
    .mapped_o (dec_mapped),
    .deny_o   (dec_deny)
  );

  bac_post_buf #(
    .ADDR_W(ADDR_W), .DW(DW), .NDEV(NDEV), .DEV_W(DEV_W)
  ) u_post (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .dev_i   (dec_dev),
    .addr_i  (addr_i),
    .data_i  (wdata_i),
    .be_i    ({!uds_n_i, !lds_n_i}),
    .ready_i (wr_ready_i),
    .full_o  (wr_valid_o),
    .dev_o   (wr_sel_o),
    .addr_o  (wr_addr_o),
    .data_o  (wr_data_o),
    .be_o    (wr_be_o)
  );

  bac_seq #(
    .ADDR_W(ADDR_W), .DW(DW), .NDEV(NDEV), .DEV_W(DEV_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .as_n_i     (as_n_i),
    .uds_n_i    (uds_n_i),
    .lds_n_i    (lds_n_i),
    .rw_n_i     (rw_n_i),
    .addr_i     (addr_i),
    .dev_i      (dec_dev),
    .mapped_i   (dec_mapped),
    .deny_i     (dec_deny),
    .buf_full_i (wr_valid_o),
    .buf_dev_i  (wr_sel_o),
    .rd_ready_i (rd_ready_i),
    .rd_data_i  (rd_data_i),
    .load_o     (load),
    .rd_valid_o (rd_valid_o),
    .cur_dev_o  (rd_sel_o),
    .cur_addr_o (rd_addr_o),
    .cur_be_o   (rd_be_o),
    .rdata_o    (rdata_o),
    .ack_o      (ack),
    .err_o      (err)
  );

  assign dtack_n_o = !ack;
  assign berr_n_o  = !err;

endmodule

// File: rtl/bac_chk.sv
module bac_chk #(
  parameter int ADDR_W     = 23,
  parameter int DW         = 16,
  parameter int NDEV       = 3,
  parameter int WIN_W      = 16,
  parameter int PROT_WORDS = 512,
  parameter int DEV_W      = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic [2:0]        fc_i,
  input logic              as_n_i,
  input logic              rw_n_i,
  input logic              dtack_n_o,
  input logic              berr_n_o,
  input logic              rd_valid_o,
  input logic [NDEV-1:0]   rd_ready_i,
  input logic [DEV_W-1:0]  rd_sel_o,
  input logic              wr_valid_o,
  input logic [NDEV-1:0]   wr_ready_i,
  input logic [DEV_W-1:0]  wr_sel_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [DW-1:0]     wr_data_o,
  input logic [1:0]        wr_be_o
);
  logic user_prot_wr;
  logic unmapped;

  assign user_prot_wr = !as_n_i && !rw_n_i && (addr_i < ADDR_W'(PROT_WORDS)) &&
                        !((fc_i == 3'b101) || (fc_i == 3'b110));
  assign unmapped     = !as_n_i && (addr_i[ADDR_W-1:WIN_W] >= (ADDR_W-WIN_W)'(NDEV));

  // R10
  resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dtack_n_o && !berr_n_o));

  // R10
  resp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    as_n_i |=> (dtack_n_o && berr_n_o));

  // R6
  post_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i[wr_sel_o]) |=>
      (wr_valid_o && $stable(wr_sel_o) && $stable(wr_addr_o) &&
       $stable(wr_data_o) && $stable(wr_be_o)));

  // R4
  rd_ack_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dtack_n_o) && rw_n_i) |-> $past(rd_valid_o && rd_ready_i[rd_sel_o]));

  // R9
  prot_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    user_prot_wr |-> dtack_n_o);

  // R2
  unmapped_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> (dtack_n_o && !rd_valid_o));

endmodule

bind bus_ack_ctrl bac_chk #(
  .ADDR_W(ADDR_W), .DW(DW), .NDEV(NDEV), .WIN_W(WIN_W),
  .PROT_WORDS(PROT_WORDS), .DEV_W(DEV_W)
) u_bac_chk (.*);

// File: tb/tb_bus_ack_ctrl.sv
module tb_bus_ack_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [22:0] addr = '0;
  logic [2:0]  fc = 3'b001;
  logic        as_n = 1'b1, uds_n = 1'b1, lds_n = 1'b1, rw_n = 1'b1;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        dtack_n, berr_n;
  logic        rd_valid;
  logic [2:0]  rd_ready = 3'b111;
  logic [1:0]  rd_sel;
  logic [22:0] rd_addr;
  logic [1:0]  rd_be;
  logic [15:0] rd_data;
  logic        wr_valid;
  logic [2:0]  wr_ready = 3'b000;
  logic [1:0]  wr_sel;
  logic [22:0] wr_addr;
  logic [15:0] wr_data;
  logic [1:0]  wr_be;

  int n_chk = 0, n_bad = 0;
  int rd_seen = 0, d_cnt = 0;
  logic [1:0]  d_sel;
  logic [22:0] d_addr;
  logic [15:0] d_data;
  logic [1:0]  d_be;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] pat(input logic [1:0] dv, input logic [22:0] a);
    return {dv, a[13:0]} ^ 16'hA5C3;
  endfunction

  assign rd_data = pat(rd_sel, rd_addr);

  bus_ack_ctrl dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .fc_i(fc), .as_n_i(as_n),
    .uds_n_i(uds_n), .lds_n_i(lds_n), .rw_n_i(rw_n), .wdata_i(wdata),
    .rdata_o(rdata), .dtack_n_o(dtack_n), .berr_n_o(berr_n),
    .rd_valid_o(rd_valid), .rd_ready_i(rd_ready), .rd_sel_o(rd_sel),
    .rd_addr_o(rd_addr), .rd_be_o(rd_be), .rd_data_i(rd_data),
    .wr_valid_o(wr_valid), .wr_ready_i(wr_ready), .wr_sel_o(wr_sel),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_be_o(wr_be)
  );

  // device-side observers
  always @(posedge clk) begin
    if (rd_valid) rd_seen <= rd_seen + 1;
    if (wr_valid && wr_ready[wr_sel]) begin
      d_cnt  <= d_cnt + 1;
      d_sel  <= wr_sel;
      d_addr <= wr_addr;
      d_data <= wr_data;
      d_be   <= wr_be;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one processor bus cycle; lat = edges after the first sampling edge until a response
  task automatic bus(input bit wr, input logic [22:0] a, input logic [2:0] f,
                     input bit u, input bit l, input logic [15:0] d,
                     input int raise_at, input bit raise_wr, input int rdev,
                     output int lat, output bit got_err, output logic [15:0] rdat);
    @(negedge clk);
    addr = a; fc = f; rw_n = !wr; wdata = d;
    as_n = 1'b0; uds_n = !u; lds_n = !l;
    lat = -1;
    for (int c = 1; c <= 40; c++) begin
      @(posedge clk); #1;
      if (!dtack_n || !berr_n) begin lat = c - 1; break; end
      if (c == raise_at) begin
        if (raise_wr) wr_ready[rdev] = 1'b1;
        else          rd_ready[rdev] = 1'b1;
      end
    end
    got_err = !berr_n;
    rdat    = rdata;
    check("R10 exclusive", {31'b0, (!dtack_n && !berr_n)}, 32'd0);
    @(negedge clk);
    as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1;
    @(posedge clk); #1;
    check("R10 release", {30'b0, dtack_n, berr_n}, 32'd3);
  endtask

  task automatic drain_all();
    @(negedge clk); wr_ready = 3'b111;
    repeat (2) @(negedge clk);
    wr_ready = 3'b000;
  endtask

  task automatic t_reset();
    check("R1 dtack", {31'b0, dtack_n}, 32'd1);
    check("R1 berr", {31'b0, berr_n}, 32'd1);
    check("R1 req", {30'b0, rd_valid, wr_valid}, 32'd0);
  endtask

  task automatic t_fast_write();
    int lat; bit e; logic [15:0] r; int c0;
    bus(1, 23'h01_0040, 3'b001, 1, 1, 16'hBEEF, -1, 0, 0, lat, e, r);
    check("R3 write lat", lat, 0);
    check("R3 write err", {31'b0, e}, 0);
    check("R3 post valid", {31'b0, wr_valid}, 1);
    check("R3 post fields", {wr_sel, wr_be, wr_addr}, {2'd1, 2'b11, 23'h01_0040});
    check("R3 post data", wr_data, 16'hBEEF);
    repeat (3) @(negedge clk);
    check("R6 hold", {wr_valid, wr_sel, wr_addr, wr_data}, {1'b1, 2'd1, 23'h01_0040, 16'hBEEF});
    c0 = d_cnt;
    drain_all();
    check("R6 drained", d_cnt - c0, 1);
    check("R6 drain data", {d_sel, d_data}, {2'd1, 16'hBEEF});
    check("R6 empty", {31'b0, wr_valid}, 0);
  endtask

  task automatic t_byte_writes();
    int lat; bit e; logic [15:0] r;
    bus(1, 23'h00_0300, 3'b001, 0, 1, 16'h00AA, -1, 0, 0, lat, e, r);
    check("R3 lower be", {wr_be, wr_sel}, {2'b01, 2'd0});
    drain_all();
    bus(1, 23'h02_0008, 3'b001, 1, 0, 16'h5500, -1, 0, 0, lat, e, r);
    check("R3 upper be", {wr_be, wr_sel}, {2'b10, 2'd2});
    drain_all();
    check("R3 upper drained", {d_be, d_data}, {2'b10, 16'h5500});
  endtask

  task automatic t_read_fast();
    int lat; bit e; logic [15:0] r;
    rd_ready = 3'b111;
    bus(0, 23'h02_1234, 3'b001, 1, 1, 0, -1, 0, 0, lat, e, r);
    check("R4 read lat", lat, 1);
    check("R4 read data", r, pat(2'd2, 23'h02_1234));
  endtask

  task automatic t_read_wait();
    int lat; bit e; logic [15:0] r;
    rd_ready = 3'b110;
    bus(0, 23'h00_0400, 3'b001, 1, 1, 0, 4, 0, 0, lat, e, r);
    check("R5 wait lat", lat, 4);
    check("R5 wait data", r, pat(2'd0, 23'h00_0400));
    rd_ready = 3'b111;
  endtask

  task automatic t_read_blocked();
    int lat; bit e; logic [15:0] r; int c0;
    bus(1, 23'h01_0002, 3'b001, 1, 1, 16'h1111, -1, 0, 0, lat, e, r);
    c0 = d_cnt;
    bus(0, 23'h01_0010, 3'b001, 1, 1, 0, 3, 1, 1, lat, e, r);
    check("R7 blocked lat", lat, 4);
    check("R7 blocked data", r, pat(2'd1, 23'h01_0010));
    check("R7 drained first", d_cnt - c0, 1);
    wr_ready = 3'b000;
  endtask

  task automatic t_read_other();
    int lat; bit e; logic [15:0] r;
    bus(1, 23'h01_0004, 3'b001, 1, 1, 16'h2222, -1, 0, 0, lat, e, r);
    bus(0, 23'h02_0020, 3'b001, 1, 1, 0, -1, 0, 0, lat, e, r);
    check("R11 other lat", lat, 1);
    check("R11 still pending", {wr_valid, wr_sel}, {1'b1, 2'd1});
    drain_all();
  endtask

  task automatic t_write_full();
    int lat; bit e; logic [15:0] r;
    bus(1, 23'h00_0800, 3'b001, 1, 1, 16'h3333, -1, 0, 0, lat, e, r);
    bus(1, 23'h02_0100, 3'b001, 1, 1, 16'h4444, 3, 1, 0, lat, e, r);
    check("R8 full lat", lat, 4);
    check("R8 first drained", {d_sel, d_data}, {2'd0, 16'h3333});
    check("R8 second posted", {wr_valid, wr_sel, wr_data}, {1'b1, 2'd2, 16'h4444});
    drain_all();
  endtask

  task automatic t_protect();
    int lat; bit e; logic [15:0] r; int c0;
    c0 = d_cnt;
    bus(1, 23'h00_0010, 3'b001, 1, 1, 16'hDEAD, -1, 0, 0, lat, e, r);
    check("R9 user data err", {lat[7:0], 7'b0, e}, {8'd0, 8'd1});
    bus(1, 23'h00_01FF, 3'b010, 1, 1, 16'hDEAD, -1, 0, 0, lat, e, r);
    check("R9 user prog last word err", {31'b0, e}, 1);
    check("R9 not posted", {wr_valid, 8'(d_cnt - c0)}, 0);
    bus(1, 23'h00_0010, 3'b110, 1, 1, 16'hCAFE, -1, 0, 0, lat, e, r);
    check("R9 super ack", {lat[7:0], 7'b0, e}, 0);
    check("R9 super posted", {wr_valid, wr_addr}, {1'b1, 23'h00_0010});
    drain_all();
    bus(1, 23'h00_0200, 3'b001, 1, 1, 16'h7777, -1, 0, 0, lat, e, r);
    check("R9 boundary ack", {31'b0, e}, 0);
    drain_all();
    bus(0, 23'h00_0000, 3'b001, 1, 1, 0, -1, 0, 0, lat, e, r);
    check("R9 user read ok", {lat[7:0], 7'b0, e}, {8'd1, 8'd0});
  endtask

  task automatic t_unmapped();
    int lat; bit e; logic [15:0] r; int s0, c0;
    s0 = rd_seen; c0 = d_cnt;
    bus(0, 23'h03_0000, 3'b101, 1, 1, 0, -1, 0, 0, lat, e, r);
    check("R2 read err", {lat[7:0], 7'b0, e}, {8'd0, 8'd1});
    bus(1, 23'h7F_0000, 3'b101, 1, 1, 16'h9999, -1, 0, 0, lat, e, r);
    check("R2 write err", {31'b0, e}, 1);
    repeat (2) @(negedge clk);
    check("R2 no request", {wr_valid, 8'(rd_seen - s0), 8'(d_cnt - c0)}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    t_fast_write();
    t_byte_writes();
    t_read_fast();
    t_read_wait();
    t_read_blocked();
    t_read_other();
    t_write_full();
    t_protect();
    t_unmapped();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule